// File: doc/BRIEF.md
# BCD Calendar Timekeeping Chain

This block keeps wall-clock time and calendar date as a cascade of packed-BCD counters. A clock-enable input arrives at the 32.768 kHz timebase rate. A prescaler counts these enables and issues one tick per second. Each tick advances the seconds. Carries then ripple through minutes, a 24-hour hour field, day of week, date, month and a two-digit year. The block picks the length of each month on its own and gives February a 29th day in leap years.

Software presets the calendar through a load port. Each field has its own write strobe, and all strobes share one data byte. Writing the seconds field also restarts the prescaler, so a fresh second begins at the moment of the write. The seven fields are plain outputs, together with a one-cycle pulse for each completed second. A separate block provides the bus-visible register view.

Top module: `bcd_calendar_chain`

## Requirements
- R1: A second tick occurs on every PRESCALE_DIV-th cycle with `tick_en` high. `sec_pulse_o` is high for exactly one cycle, in the cycle where the seconds output first shows the advanced value.
- R2: Seconds and minutes each count 00 to 59. On an advance from 59 they go to 00 and advance the next field.
- R3: Hours count 00 to 23. An advance from 23 gives 00 and advances both day of week and date.
- R4: The date runs from 01 to the length of the current month, then goes to 01 and advances the month. Months 04, 06, 09 and 11 have 30 days. February has 28 days, or 29 in a leap year. Every other month has 31 days.
- R5: The month counts 01 to 12, and an advance from 12 gives 01 and advances the year. The year counts 00 to 99 and wraps to 00.
- R6: Day of week counts 1 to 7 and wraps from 7 to 1 at each midnight.
- R7: A year is a leap year when its value is divisible by 4, and 00 counts as a leap year.
- R8: A low digit of 9 or more carries into the high digit as 0. Any field whose raw byte is at or above its maximum wraps to its minimum on the next advance and passes a carry on, so invalid loaded codes become valid again.
- R9: After reset the fields read 00:00:00, day 1, date 01, month 01, year 00, and `sec_pulse_o` is low.
- R10: When `ld_we[i]` is high, field i takes `ld_data` at the next clock edge. The bit order is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A field being loaded does not advance and sends no carry in that cycle.
- R11: Writing the seconds field clears the prescaler and suppresses the tick in that cycle. The next tick comes exactly PRESCALE_DIV enables later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the timebase rate |
| ld_we | input | 7 | Per-field write strobes (bit 0 seconds to bit 6 year) |
| ld_data | input | 8 | Packed-BCD value written to every strobed field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| sec_pulse_o | output | 1 | One-cycle pulse per second advance |

## Verification
The bench targets several boundaries:
- End of month in every month, with years on both sides of the leap rule, including year 00 and the wrap from 99 to 00. A wrong length table or a wrong leap test shows up as a date of 29, 30 or 31 that should have rolled over, or as a missing February 29.
- Invalid seconds codes such as 5A and 1A, which a chain without normalisation would leave stuck or carry into non-BCD values.
- Loads that coincide with carries. A design that lets a loaded field also advance or pass a carry would show an hour or date off by one.
- A seconds write during a partly counted second. A prescaler that is not restarted delivers the next pulse early.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

   localparam int NUM_FIELDS = 7;

   typedef enum int unsigned {
      FLD_SEC   = 0,
      FLD_MIN   = 1,
      FLD_HOUR  = 2,
      FLD_DOW   = 3,
      FLD_DATE  = 4,
      FLD_MONTH = 5,
      FLD_YEAR  = 6
   } cal_field_e;

   typedef logic [7:0] bcd8_t;

   // largest legal code of a field; the date maximum is computed at run time
   function automatic bcd8_t field_max(int idx);
      case (idx)
         FLD_SEC, FLD_MIN: return 8'h59;
         FLD_HOUR:         return 8'h23;
         FLD_DOW:          return 8'h07;
         FLD_DATE:         return 8'h31;
         FLD_MONTH:        return 8'h12;
         default:          return 8'h99;
      endcase
   endfunction

   // value a field takes when it wraps, also used as its reset value
   function automatic bcd8_t field_min(int idx);
      case (idx)
         FLD_DOW, FLD_DATE, FLD_MONTH: return 8'h01;
         default:                      return 8'h00;
      endcase
   endfunction

   // divisible-by-4 test on a two-digit BCD number
   function automatic logic bcd_div4(bcd8_t y);
      logic [3:0] hi_d;
      logic [3:0] lo_d;
      hi_d = y[7:4];
      lo_d = y[3:0];
      if (!hi_d[0]) return (lo_d == 4'd0) || (lo_d == 4'd4) || (lo_d == 4'd8);
      return (lo_d == 4'd2) || (lo_d == 4'd6);
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   localparam int  CNT_W  = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2 = ((DIV & (DIV - 1)) == 0);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   generate
      if (IS_POW2) begin : g_pow2
         // counter wraps on its own, terminal count is all ones
         assign at_last = &cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q <= '0;
            else if (en)       cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_modulo
         assign at_last = (cnt_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q <= '0;
            else if (en)       cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   assign tick = en && at_last && !clr;

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
   import calendar_pkg::*;
(
   input  bcd8_t month,
   input  bcd8_t year,
   output bcd8_t last_date
);
   logic leap;

   assign leap = bcd_div4(year);

   always_comb begin
      case (month)
         8'h02:                      last_date = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
         default:                    last_date = 8'h31;
      endcase
   end

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
   import calendar_pkg::*;
#(
   parameter bcd8_t MIN_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  inc,
   input  bcd8_t max_val,
   input  logic  ld,
   input  bcd8_t ld_val,
   output bcd8_t val
);
   bcd8_t val_q;
   bcd8_t nxt;

   // raw compare so that out-of-range codes also wrap
   always_comb begin
      if (val_q >= max_val)        nxt = MIN_VAL;
      else if (val_q[3:0] >= 4'd9) nxt = {val_q[7:4] + 4'd1, 4'd0};
      else                         nxt = {val_q[7:4], val_q[3:0] + 4'd1};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   val_q <= MIN_VAL;
      else if (ld)  val_q <= ld_val;
      else if (inc) val_q <= nxt;
   end

   assign val = val_q;

endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
   import calendar_pkg::*;
#(
   parameter int PRESCALE_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic [6:0] ld_we,
   input  logic [7:0] ld_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] dow_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o,
   output logic       sec_pulse_o
);
   generate
      if (PRESCALE_DIV < 2) begin : g_bad_div
         $error("PRESCALE_DIV must be at least 2");
      end
   endgenerate

   logic  sec_tick;
   logic  pulse_q;
   bcd8_t fld_val [NUM_FIELDS];
   bcd8_t fld_max [NUM_FIELDS];
   bcd8_t date_last;
   logic [NUM_FIELDS-1:0] at_top;
   logic [NUM_FIELDS-1:0] fld_inc;
   logic  c_sec, c_min, c_hour, c_date, c_month;

   cal_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tick_en),
      .clr   (ld_we[FLD_SEC]),
      .tick  (sec_tick)
   );

   cal_month_len u_mlen (
      .month     (fld_val[FLD_MONTH]),
      .year      (fld_val[FLD_YEAR]),
      .last_date (date_last)
   );

   // carry ripple: a loaded field neither advances nor carries
   assign c_sec   = sec_tick && !ld_we[FLD_SEC]   && at_top[FLD_SEC];
   assign c_min   = c_sec    && !ld_we[FLD_MIN]   && at_top[FLD_MIN];
   assign c_hour  = c_min    && !ld_we[FLD_HOUR]  && at_top[FLD_HOUR];
   assign c_date  = c_hour   && !ld_we[FLD_DATE]  && at_top[FLD_DATE];
   assign c_month = c_date   && !ld_we[FLD_MONTH] && at_top[FLD_MONTH];

   assign fld_inc[FLD_SEC]   = sec_tick;
   assign fld_inc[FLD_MIN]   = c_sec;
   assign fld_inc[FLD_HOUR]  = c_min;
   assign fld_inc[FLD_DOW]   = c_hour;
   assign fld_inc[FLD_DATE]  = c_hour;
   assign fld_inc[FLD_MONTH] = c_date;
   assign fld_inc[FLD_YEAR]  = c_month;

   generate
      for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
         if (gi == FLD_DATE) begin : g_dyn_max
            assign fld_max[gi] = date_last;
         end else begin : g_fix_max
            assign fld_max[gi] = field_max(gi);
         end

         assign at_top[gi] = (fld_val[gi] >= fld_max[gi]);

         cal_bcd_field #(.MIN_VAL(field_min(gi))) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (fld_inc[gi]),
            .max_val (fld_max[gi]),
            .ld      (ld_we[gi]),
            .ld_val  (ld_data),
            .val     (fld_val[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= sec_tick;
   end

   assign sec_o       = fld_val[FLD_SEC];
   assign min_o       = fld_val[FLD_MIN];
   assign hour_o      = fld_val[FLD_HOUR];
   assign dow_o       = fld_val[FLD_DOW];
   assign date_o      = fld_val[FLD_DATE];
   assign month_o     = fld_val[FLD_MONTH];
   assign year_o      = fld_val[FLD_YEAR];
   assign sec_pulse_o = pulse_q;

endmodule

// File: rtl/bcd_calendar_chain_chk.sv
module bcd_calendar_chain_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [6:0] ld_we,
   input logic [7:0] sec_o,
   input logic [7:0] hour_o,
   input logic [7:0] dow_o,
   input logic [7:0] date_o,
   input logic       sec_pulse_o
);
   // R1: the pulse never lasts two cycles
   p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse_o |=> !sec_pulse_o);

   // R1: seconds move only on a pulse or after a load
   p_sec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_pulse_o && !$past(ld_we[0])) |-> (sec_o == $past(sec_o)));

   // R8: a seconds value produced by an advance is legal BCD
   p_sec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse_o |-> (sec_o <= 8'h59 && sec_o[3:0] <= 4'd9));

   // R6: midnight moves the day of week
   p_midnight_dow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hour_o == 8'h00 && $past(hour_o) == 8'h23 && !$past(ld_we[2]))
         |-> (dow_o != $past(dow_o) || $past(ld_we[3])));

   // R4: an advancing date never lands on 00
   p_date_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (date_o != $past(date_o) && !$past(ld_we[4])) |-> (date_o != 8'h00));

endmodule

bind bcd_calendar_chain bcd_calendar_chain_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_we       (ld_we),
   .sec_o       (sec_o),
   .hour_o      (hour_o),
   .dow_o       (dow_o),
   .date_o      (date_o),
   .sec_pulse_o (sec_pulse_o)
);

// File: tb/bcd_calendar_chain_tb.sv
module bcd_calendar_chain_tb_top;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [6:0] ld_we = '0;
   logic [7:0] ld_data = '0;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
   logic       sec_pulse_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_f [7];
   int         m_pre;
   bit         m_pulse;

   always #4 clk = ~clk;

   bcd_calendar_chain #(.PRESCALE_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_we(ld_we), .ld_data(ld_data),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
      .month_o(month_o), .year_o(year_o), .sec_pulse_o(sec_pulse_o)
   );

   function automatic int bcd2int(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] int2bcd(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   // R4 / R7: month lengths, leap when the year is a multiple of 4
   function automatic logic [7:0] days_of(logic [7:0] mo, logic [7:0] yr);
      bit lp;
      lp = (bcd2int(yr) % 4) == 0;
      if (mo == 8'h02) return lp ? 8'h29 : 8'h28;
      if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11) return 8'h30;
      return 8'h31;
   endfunction

   // R8: one advance of a field
   function automatic logic [7:0] step(logic [7:0] v, logic [7:0] mx, logic [7:0] mn);
      if (v >= mx) return mn;
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   task automatic model_reset();
      m_f[0] = 8'h00; m_f[1] = 8'h00; m_f[2] = 8'h00; m_f[3] = 8'h01;
      m_f[4] = 8'h01; m_f[5] = 8'h01; m_f[6] = 8'h00;
      m_pre = 0; m_pulse = 0;
   endtask

   // expected state after one edge: R1 R2 R3 R5 R6 R10 R11
   task automatic model_step(bit en, logic [6:0] we, logic [7:0] d);
      bit tk;
      bit c0, c1, c2, c4, c5;
      bit inc [7];
      logic [7:0] mx [7];
      tk = 0;
      if (we[0]) m_pre = 0;
      else if (en) begin
         if (m_pre == DIV - 1) begin m_pre = 0; tk = 1; end
         else m_pre++;
      end
      mx[0] = 8'h59; mx[1] = 8'h59; mx[2] = 8'h23; mx[3] = 8'h07;
      mx[4] = days_of(m_f[5], m_f[6]); mx[5] = 8'h12; mx[6] = 8'h99;
      c0 = tk && !we[0] && (m_f[0] >= mx[0]);
      c1 = c0 && !we[1] && (m_f[1] >= mx[1]);
      c2 = c1 && !we[2] && (m_f[2] >= mx[2]);
      c4 = c2 && !we[4] && (m_f[4] >= mx[4]);
      c5 = c4 && !we[5] && (m_f[5] >= mx[5]);
      inc[0] = tk; inc[1] = c0; inc[2] = c1; inc[3] = c2; inc[4] = c2; inc[5] = c4; inc[6] = c5;
      for (int i = 0; i < 7; i++) begin
         if (we[i]) m_f[i] = d;
         else if (inc[i]) m_f[i] = step(m_f[i], mx[i], (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00);
      end
      m_pulse = tk;
   endtask

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 seconds", sec_o, m_f[0]);
      chk("R2 minutes", min_o, m_f[1]);
      chk("R3 hours", hour_o, m_f[2]);
      chk("R6 day of week", dow_o, m_f[3]);
      chk("R4 date", date_o, m_f[4]);
      chk("R5 month", month_o, m_f[5]);
      chk("R5 R7 year", year_o, m_f[6]);
      chk("R1 R11 pulse", {7'd0, sec_pulse_o}, {7'd0, m_pulse});
   endtask

   // drive one cycle at the falling edge, compare at the following falling edge
   task automatic cyc(bit en, logic [6:0] we, logic [7:0] d);
      tick_en = en; ld_we = we; ld_data = d;
      model_step(en, we, d);
      @(negedge clk);
      compare_all();
   endtask

   // R10: preset one field per cycle, seconds last so R11 restarts the second
   task automatic preset(logic [7:0] y, logic [7:0] mo, logic [7:0] dt, logic [7:0] dw,
                         logic [7:0] h, logic [7:0] mi, logic [7:0] s);
      cyc(0, 7'b1000000, y);
      cyc(0, 7'b0100000, mo);
      cyc(0, 7'b0010000, dt);
      cyc(0, 7'b0001000, dw);
      cyc(0, 7'b0000100, h);
      cyc(0, 7'b0000010, mi);
      cyc(0, 7'b0000001, s);
   endtask

   task automatic run_on(int n);
      for (int i = 0; i < n; i++) cyc(1, '0, 8'h00);
   endtask

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset values
      chk("R9 sec", sec_o, 8'h00);   chk("R9 min", min_o, 8'h00);
      chk("R9 hour", hour_o, 8'h00); chk("R9 dow", dow_o, 8'h01);
      chk("R9 date", date_o, 8'h01); chk("R9 month", month_o, 8'h01);
      chk("R9 year", year_o, 8'h00); chk("R9 pulse", {7'd0, sec_pulse_o}, 8'h00);

      // R1 basic counting
      run_on(3 * DIV + 1);
      chk("R1 three seconds", sec_o, 8'h03);

      // R7 year 00 is leap
      preset(8'h00, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
      run_on(DIV);
      chk("R7 feb 29 in 00", date_o, 8'h29);
      chk("R6 dow wrap", dow_o, 8'h01);
      chk("R3 hour wrap", hour_o, 8'h00);

      // R4 non-leap February
      preset(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      run_on(DIV);
      chk("R4 feb end date", date_o, 8'h01);
      chk("R4 feb end month", month_o, 8'h03);

      // R5 year wrap
      preset(8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
      run_on(DIV);
      chk("R5 year wrap", year_o, 8'h00);
      chk("R5 month wrap", month_o, 8'h01);

      // R8 invalid seconds codes
      cyc(0, 7'b0000001, 8'h5A);
      run_on(DIV);
      chk("R8 5A wraps", sec_o, 8'h00);
      cyc(0, 7'b0000001, 8'h1A);
      run_on(DIV);
      chk("R8 1A normalises", sec_o, 8'h20);

      // R11 seconds write mid-second restarts the prescaler
      run_on(DIV - 1);
      cyc(1, 7'b0000001, 8'h10);
      run_on(DIV - 1);
      chk("R11 no early tick", sec_o, 8'h10);
      run_on(1);
      chk("R11 tick after full period", sec_o, 8'h11);

      // R10 load coinciding with a carry: loaded minute wins, hour untouched
      preset(8'h10, 8'h05, 8'h10, 8'h04, 8'h05, 8'h59, 8'h59);
      run_on(DIV - 1);
      cyc(1, 7'b0000010, 8'h59);
      chk("R10 loaded min", min_o, 8'h59);
      chk("R10 no carry from loaded field", hour_o, 8'h05);

      // random month-end scenarios
      for (int it = 0; it < 300; it++) begin
         logic [7:0] mo, yr, dt;
         mo = int2bcd(1 + int'($urandom % 12));
         yr = int2bcd(int'($urandom % 100));
         dt = days_of(mo, yr);
         if ($urandom % 2) dt = int2bcd(bcd2int(dt) - 1);
         preset(yr, mo, dt, int2bcd(1 + int'($urandom % 7)), 8'h23, 8'h59,
                ($urandom % 5 == 0) ? 8'h5B : 8'h58 + 8'($urandom % 2));
         for (int k = 0; k < 3 * DIV + 8; k++) begin
            logic [6:0] we;
            we = '0;
            if ($urandom % 12 == 0) we[$urandom % 5] = 1'b1;
            cyc(($urandom % 4) != 0, we, int2bcd(int'($urandom % 60)));
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule